// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block holds the general-purpose working registers of a small 8-bit RISC core: 32 bytes, read through two independent combinational byte ports and a 16-bit pair port, and written through one port that stores either a single byte or an aligned pair of bytes in one clock. Because reads are combinational and writes land on the clock edge, an operand fetch, the operation and the write-back of its result all fit in one cycle.

The top six registers double as three 16-bit address pointers (pointer 0 in registers 26/27, pointer 1 in 28/29, pointer 2 in 30/31, low byte in the even register). They are exported at all times. A pointer port produces an effective address from a selected pointer with one of four modes: displacement, post-increment, pre-decrement or plain. The incrementing and decrementing modes write the updated pointer back into the register file.

A registered data-space decoder splits any 16-bit data address into one of three regions (register bytes, short I/O space, extended I/O plus memory) and returns the offset within the region. Register bytes sit at the bottom of the data space, the 64 short I/O locations follow them, and everything from 0x60 upward belongs to the memory region.

Top module: `gpr_bank`

## Requirements
- R1: While `rst` is high on a clock edge, every register becomes 0x00, and the decoder outputs become region 3'b001 with offset 0.
- R2: `rd_a_data` and `rd_b_data` show, without a clock edge, the registers addressed by `rd_a_idx` and `rd_b_idx`, independently of each other.
- R3: `rd_pair_data` shows {register (rd_a_idx with bit 0 set), register (rd_a_idx with bit 0 cleared)}, the odd register in bits 15:8.
- R4: With `wr_en` high and `wr_wide` low, `wr_data[7:0]` is stored into register `wr_idx` at the clock edge; a read of that register in the same cycle still returns the old value.
- R5: With `wr_en` and `wr_wide` high and `wr_idx` even, `wr_data[7:0]` goes to register `wr_idx` and `wr_data[15:8]` to register `wr_idx`+1 at the same edge; with `wr_idx` odd the write changes no register.
- R6: `ptrs[15:0]` = {r27,r26}, `ptrs[31:16]` = {r29,r28}, `ptrs[47:32]` = {r31,r30}, at all times.
- R7: With `ptr_en` high and `ptr_mode` = 2'b01 (post-increment), `ptr_addr` equals the selected pointer and the pointer becomes its value plus one at the edge.
- R8: With `ptr_mode` = 2'b10 (pre-decrement), `ptr_addr` equals the selected pointer minus one and the pointer takes that value at the edge.
- R9: With `ptr_mode` = 2'b00 (displacement), `ptr_addr` equals the selected pointer plus the zero-extended 6-bit `ptr_disp` and no pointer changes; `ptr_mode` = 2'b11 gives the pointer unchanged with no write-back; `ptr_sel` = 0/1/2 selects a pointer, and `ptr_sel` = 3 or `ptr_en` low gives `ptr_addr` = 0 with no write-back.
- R10: When the write port and a pointer write-back touch the same register byte in one cycle, the write port's byte is stored; the other byte of that pointer still takes the updated value.
- R11: One clock after `da_addr` is presented, `da_region` is 3'b001 with offset = address for 0x0000..0x001F, 3'b010 with offset = address - 0x20 for 0x0020..0x005F, and 3'b100 with offset = address - 0x60 for 0x0060 and above; exactly one bit is set.
- R12: Pointer arithmetic wraps modulo 2^16: post-increment of 0xFFFF gives 0x0000, pre-decrement of 0x0000 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Register index for read port A and the pair port |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_a_data | output | 8 | Read port A data |
| rd_b_data | output | 8 | Read port B data |
| rd_pair_data | output | 16 | Aligned register pair containing rd_a_idx |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | 1: pair write, 0: byte write |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| ptr_en | input | 1 | Pointer access strobe |
| ptr_sel | input | 2 | Pointer select: 0, 1, 2; 3 selects none |
| ptr_mode | input | 2 | 00 displacement, 01 post-increment, 10 pre-decrement, 11 plain |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_addr | output | 16 | Effective address |
| ptrs | output | 48 | All three pointers, pointer 0 in bits 15:0 |
| da_addr | input | 16 | Data-space address to decode |
| da_region | output | 3 | One-hot region: bit 0 registers, bit 1 short I/O, bit 2 memory |
| da_offset | output | 16 | Offset within the selected region |

## Verification
The hardest situation to reach is a pointer write-back colliding with a write-port store to one byte of the same pointer, since it needs a pointer access and a register write aimed at overlapping storage in one cycle. The bench first loads the pointer with a pair write chosen so that the increment carries into the high byte, then issues the post-increment together with a byte store to the low register, so both bytes reveal which source won. Wrap-around at both ends of the 16-bit range is reached the same way, by loading 0xFFFF and 0x0000 through pair writes before stepping.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    PM_DISP    = 2'b00,
    PM_POSTINC = 2'b01,
    PM_PREDEC  = 2'b10,
    PM_PLAIN   = 2'b11
  } ptr_mode_e;

  localparam int RGN_REG = 0;
  localparam int RGN_IO  = 1;
  localparam int RGN_MEM = 2;
  localparam int RGN_W   = 3;

endpackage

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int NPTR = 3,
  localparam int IDX_W    = $clog2(NREG),
  localparam int SEL_W    = $clog2(NPTR + 1),
  localparam int PW       = 2 * DW,
  localparam int PTR_BASE = NREG - 2 * NPTR
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       wr_wide,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [PW-1:0]              wr_data,
  input  logic                       pwb_en,
  input  logic [SEL_W-1:0]           pwb_sel,
  input  logic [PW-1:0]              pwb_val,
  output logic [NREG-1:0][DW-1:0]    regs_o
);

  logic wr_legal;
  assign wr_legal = wr_en && (!wr_wide || !wr_idx[0]);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [IDX_W-1:0] IDX = IDX_W'(g);
    logic          hit_lo;
    logic          hit_hi;
    logic          p_hit;
    logic [DW-1:0] p_val;
    logic [DW-1:0] q;

    assign hit_lo = wr_legal && (wr_idx == IDX);

    if (g % 2 == 1) begin : g_odd
      assign hit_hi = wr_legal && wr_wide &&
                      (wr_idx[IDX_W-1:1] == IDX[IDX_W-1:1]);
    end else begin : g_even
      assign hit_hi = 1'b0;
    end

    if (g >= PTR_BASE) begin : g_ptr
      localparam int P = (g - PTR_BASE) / 2;
      assign p_hit = pwb_en && (pwb_sel == SEL_W'(P));
      if (g % 2 == 1) begin : g_hi
        assign p_val = pwb_val[PW-1:DW];
      end else begin : g_lo
        assign p_val = pwb_val[DW-1:0];
      end
    end else begin : g_plain
      assign p_hit = 1'b0;
      assign p_val = '0;
    end

    always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (hit_lo) q <= wr_data[DW-1:0];
      else if (hit_hi) q <= wr_data[PW-1:DW];
      else if (p_hit)  q <= p_val;
    end

    assign regs_o[g] = q;
  end

endmodule

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit import gpr_pkg::*; #(
  parameter int NPTR   = 3,
  parameter int PW     = 16,
  parameter int DISP_W = 6,
  localparam int SEL_W = $clog2(NPTR + 1)
) (
  input  logic                      en,
  input  logic [SEL_W-1:0]          sel,
  input  logic [1:0]                mode,
  input  logic [DISP_W-1:0]         disp,
  input  logic [NPTR-1:0][PW-1:0]   ptr_vals,
  output logic [PW-1:0]             eff_addr,
  output logic                      wb_en,
  output logic [SEL_W-1:0]          wb_sel,
  output logic [PW-1:0]             wb_val
);

  logic [PW-1:0] cur;
  logic          found;

  always_comb begin
    cur   = '0;
    found = 1'b0;
    for (int p = 0; p < NPTR; p++) begin
      if (sel == SEL_W'(p)) begin
        cur   = ptr_vals[p];
        found = 1'b1;
      end
    end
  end

  always_comb begin
    eff_addr = cur;
    wb_val   = cur;
    wb_en    = 1'b0;
    case (ptr_mode_e'(mode))
      PM_DISP:    eff_addr = cur + PW'(disp);
      PM_POSTINC: begin
        wb_val = cur + PW'(1);
        wb_en  = 1'b1;
      end
      PM_PREDEC:  begin
        eff_addr = cur - PW'(1);
        wb_val   = cur - PW'(1);
        wb_en    = 1'b1;
      end
      default:    eff_addr = cur;
    endcase
    if (!(en && found)) begin
      eff_addr = '0;
      wb_en    = 1'b0;
    end
  end

  assign wb_sel = sel;

endmodule

// File: rtl/gpr_dspace_decode.sv
module gpr_dspace_decode import gpr_pkg::*; #(
  parameter int AW      = 16,
  parameter int NREG    = 32,
  parameter int IO_SIZE = 64,
  localparam int IO_BASE  = NREG,
  localparam int MEM_BASE = NREG + IO_SIZE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  output logic [RGN_W-1:0]  region,
  output logic [AW-1:0]     offset
);

  logic [RGN_W-1:0] region_d;
  logic [AW-1:0]    offset_d;

  always_comb begin
    region_d = '0;
    if (addr < AW'(IO_BASE)) begin
      region_d[RGN_REG] = 1'b1;
      offset_d          = addr;
    end else if (addr < AW'(MEM_BASE)) begin
      region_d[RGN_IO] = 1'b1;
      offset_d         = addr - AW'(IO_BASE);
    end else begin
      region_d[RGN_MEM] = 1'b1;
      offset_d          = addr - AW'(MEM_BASE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      region <= RGN_W'(1) << RGN_REG;
      offset <= '0;
    end else begin
      region <= region_d;
      offset <= offset_d;
    end
  end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank import gpr_pkg::*; #(
  parameter int NREG    = 32,
  parameter int DW      = 8,
  parameter int NPTR    = 3,
  parameter int AW      = 16,
  parameter int IO_SIZE = 64,
  parameter int DISP_W  = 6,
  localparam int IDX_W    = $clog2(NREG),
  localparam int SEL_W    = $clog2(NPTR + 1),
  localparam int PW       = 2 * DW,
  localparam int PTR_BASE = NREG - 2 * NPTR
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      rd_a_idx,
  input  logic [IDX_W-1:0]      rd_b_idx,
  output logic [DW-1:0]         rd_a_data,
  output logic [DW-1:0]         rd_b_data,
  output logic [PW-1:0]         rd_pair_data,
  input  logic                  wr_en,
  input  logic                  wr_wide,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [PW-1:0]         wr_data,
  input  logic                  ptr_en,
  input  logic [SEL_W-1:0]      ptr_sel,
  input  logic [1:0]            ptr_mode,
  input  logic [DISP_W-1:0]     ptr_disp,
  output logic [PW-1:0]         ptr_addr,
  output logic [NPTR*PW-1:0]    ptrs,
  input  logic [AW-1:0]         da_addr,
  output logic [RGN_W-1:0]      da_region,
  output logic [AW-1:0]         da_offset
);

  logic [NREG-1:0][DW-1:0]  regs;
  logic [NPTR-1:0][PW-1:0]  ptr_vals;
  logic                     pwb_en;
  logic [SEL_W-1:0]         pwb_sel;
  logic [PW-1:0]            pwb_val;

  gpr_storage #(.NREG(NREG), .DW(DW), .NPTR(NPTR)) i_storage (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_wide (wr_wide),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .pwb_en  (pwb_en),
    .pwb_sel (pwb_sel),
    .pwb_val (pwb_val),
    .regs_o  (regs)
  );

  assign rd_a_data    = regs[rd_a_idx];
  assign rd_b_data    = regs[rd_b_idx];
  assign rd_pair_data = {regs[{rd_a_idx[IDX_W-1:1], 1'b1}],
                         regs[{rd_a_idx[IDX_W-1:1], 1'b0}]};

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptr_vals[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end
  assign ptrs = ptr_vals;

  gpr_ptr_unit #(.NPTR(NPTR), .PW(PW), .DISP_W(DISP_W)) i_ptr (
    .en       (ptr_en),
    .sel      (ptr_sel),
    .mode     (ptr_mode),
    .disp     (ptr_disp),
    .ptr_vals (ptr_vals),
    .eff_addr (ptr_addr),
    .wb_en    (pwb_en),
    .wb_sel   (pwb_sel),
    .wb_val   (pwb_val)
  );

  gpr_dspace_decode #(.AW(AW), .NREG(NREG), .IO_SIZE(IO_SIZE)) i_decode (
    .clk    (clk),
    .rst    (rst),
    .addr   (da_addr),
    .region (da_region),
    .offset (da_offset)
  );

endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int NREG    = 32,
  parameter int DW      = 8,
  parameter int NPTR    = 3,
  parameter int AW      = 16,
  parameter int IO_SIZE = 64,
  parameter int DISP_W  = 6,
  localparam int IDX_W    = $clog2(NREG),
  localparam int SEL_W    = $clog2(NPTR + 1),
  localparam int PW       = 2 * DW,
  localparam int MEM_BASE = NREG + IO_SIZE
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  wr_wide,
  input logic [IDX_W-1:0]      wr_idx,
  input logic                  ptr_en,
  input logic [SEL_W-1:0]      ptr_sel,
  input logic [1:0]            ptr_mode,
  input logic [PW-1:0]         ptr_addr,
  input logic [NPTR*PW-1:0]    ptrs,
  input logic [AW-1:0]         da_addr,
  input logic [2:0]            da_region
);

  logic sel_ok;
  assign sel_ok = ptr_en && (int'(ptr_sel) < NPTR);

  AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(da_region) == 1); // R11

  AST_REGION_MEM: assert property (@(posedge clk) disable iff (rst)
    (da_addr >= AW'(MEM_BASE)) |=> da_region[2]); // R11

  AST_WIDE_ODD_NOP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && wr_idx[0] && !ptr_en) |=> $stable(ptrs)); // R5

  AST_POSTINC_ADDR: assert property (@(posedge clk) disable iff (rst)
    (sel_ok && ptr_mode == 2'b01) |-> ptr_addr == ptrs[ptr_sel*PW +: PW]); // R7

  AST_POSTINC_WB: assert property (@(posedge clk) disable iff (rst)
    (sel_ok && ptr_mode == 2'b01 && !wr_en)
      |=> ptrs[$past(ptr_sel)*PW +: PW] == PW'($past(ptr_addr) + 1)); // R7

  AST_PREDEC_WB: assert property (@(posedge clk) disable iff (rst)
    (sel_ok && ptr_mode == 2'b10 && !wr_en)
      |=> ptrs[$past(ptr_sel)*PW +: PW] == $past(ptr_addr)); // R8

  AST_DISP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (ptr_en && ptr_mode == 2'b00 && !wr_en) |=> $stable(ptrs)); // R9

  AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sel_ok |-> ptr_addr == '0); // R9

endmodule

bind gpr_bank gpr_bank_chk #(
  .NREG(NREG), .DW(DW), .NPTR(NPTR), .AW(AW), .IO_SIZE(IO_SIZE), .DISP_W(DISP_W)
) i_gpr_bank_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_wide   (wr_wide),
  .wr_idx    (wr_idx),
  .ptr_en    (ptr_en),
  .ptr_sel   (ptr_sel),
  .ptr_mode  (ptr_mode),
  .ptr_addr  (ptr_addr),
  .ptrs      (ptrs),
  .da_addr   (da_addr),
  .da_region (da_region)
);

// File: tb/test_gpr_bank.sv
module test_gpr_bank;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data;
  logic [15:0] rd_pair_data, wr_data, ptr_addr, da_addr, da_offset;
  logic        wr_en, wr_wide, ptr_en;
  logic [1:0]  ptr_sel, ptr_mode;
  logic [5:0]  ptr_disp;
  logic [47:0] ptrs;
  logic [2:0]  da_region;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpr_bank i_gpr_bank (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_pair_data(rd_pair_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_disp(ptr_disp),
    .ptr_addr(ptr_addr), .ptrs(ptrs),
    .da_addr(da_addr), .da_region(da_region), .da_offset(da_offset)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_wide = 0; wr_idx = 0; wr_data = 0;
    ptr_en = 0; ptr_sel = 0; ptr_mode = 0; ptr_disp = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wide_wr(input logic [4:0] idx, input logic [15:0] d);
    wr_en = 1; wr_wide = 1; wr_idx = idx; wr_data = d;
    step();
  endtask

  task automatic t_reset();
    rd_a_idx = 5'd26; rd_b_idx = 5'd31; #1;
    chk("R1 rd_a after reset", 32'(rd_a_data), 0);
    chk("R1 rd_b after reset", 32'(rd_b_data), 0);
    chk("R1 ptrs after reset", 32'(ptrs[31:0]) | 32'(ptrs[47:32]), 0);
    chk("R1 region after reset", 32'(da_region), 32'h1);
  endtask

  task automatic t_narrow();
    wr_en = 1; wr_idx = 5'd5; wr_data = 16'hFFA5; rd_a_idx = 5'd5; #1;
    chk("R4 same-cycle read old", 32'(rd_a_data), 0);
    step();
    chk("R4 byte write visible", 32'(rd_a_data), 32'hA5);
    wr_en = 1; wr_idx = 5'd7; wr_data = 16'h003C;
    step();
    rd_a_idx = 5'd5; rd_b_idx = 5'd7; #1;
    chk("R2 port A", 32'(rd_a_data), 32'hA5);
    chk("R2 port B", 32'(rd_b_data), 32'h3C);
    rd_a_idx = 5'd6; #1;
    chk("R3 pair read", 32'(rd_pair_data), 32'h3C00);
  endtask

  task automatic t_wide();
    wide_wr(5'd26, 16'h1234);
    chk("R6 pointer 0", 32'(ptrs[15:0]), 32'h1234);
    rd_a_idx = 5'd27; rd_b_idx = 5'd26; #1;
    chk("R5 pair hi byte", 32'(rd_a_data), 32'h12);
    chk("R5 pair lo byte", 32'(rd_b_data), 32'h34);
    chk("R3 pair read odd index", 32'(rd_pair_data), 32'h1234);
    wide_wr(5'd29, 16'hBEEF);
    rd_a_idx = 5'd29; rd_b_idx = 5'd28; #1;
    chk("R5 odd wide r29 unchanged", 32'(rd_a_data), 0);
    chk("R5 odd wide r28 unchanged", 32'(rd_b_data), 0);
    chk("R5 odd wide r30 unchanged", 32'(ptrs[47:32]), 0);
  endtask

  task automatic t_postinc();
    wide_wr(5'd30, 16'hFFFF);
    ptr_en = 1; ptr_sel = 2; ptr_mode = 2'b01; #1;
    chk("R7 post-inc address", 32'(ptr_addr), 32'hFFFF);
    step();
    chk("R12 post-inc wrap", 32'(ptrs[47:32]), 0);
    wide_wr(5'd28, 16'h0100);
    ptr_en = 1; ptr_sel = 1; ptr_mode = 2'b01;
    step();
    chk("R7 post-inc result", 32'(ptrs[31:16]), 32'h0101);
  endtask

  task automatic t_predec();
    wide_wr(5'd26, 16'h0000);
    ptr_en = 1; ptr_sel = 0; ptr_mode = 2'b10; #1;
    chk("R8 pre-dec address wrap", 32'(ptr_addr), 32'hFFFF);
    step();
    chk("R12 pre-dec wrap", 32'(ptrs[15:0]), 32'hFFFF);
    wide_wr(5'd26, 16'h1000);
    ptr_en = 1; ptr_sel = 0; ptr_mode = 2'b10; #1;
    chk("R8 pre-dec address", 32'(ptr_addr), 32'h0FFF);
    step();
    chk("R8 pre-dec result", 32'(ptrs[15:0]), 32'h0FFF);
  endtask

  task automatic t_disp();
    ptr_en = 1; ptr_sel = 1; ptr_mode = 2'b00; ptr_disp = 6'd63; #1;
    chk("R9 displacement address", 32'(ptr_addr), 32'h0140);
    step();
    chk("R9 displacement keeps pointer", 32'(ptrs[31:16]), 32'h0101);
    ptr_en = 1; ptr_sel = 1; ptr_mode = 2'b11; #1;
    chk("R9 plain address", 32'(ptr_addr), 32'h0101);
    step();
    chk("R9 plain keeps pointer", 32'(ptrs[31:16]), 32'h0101);
    ptr_en = 1; ptr_sel = 3; ptr_mode = 2'b01; #1;
    chk("R9 no pointer selected", 32'(ptr_addr), 0);
    step();
    chk("R9 no-select ptr0", 32'(ptrs[15:0]), 32'h0FFF);
    chk("R9 no-select ptr1", 32'(ptrs[31:16]), 32'h0101);
    chk("R9 no-select ptr2", 32'(ptrs[47:32]), 0);
  endtask

  task automatic t_prio();
    wide_wr(5'd30, 16'h12FF);
    ptr_en = 1; ptr_sel = 2; ptr_mode = 2'b01;
    wr_en = 1; wr_wide = 0; wr_idx = 5'd30; wr_data = 16'h0055;
    step();
    chk("R10 write port wins low byte", 32'(ptrs[47:32]), 32'h1355);
  endtask

  task automatic dec_one(input logic [15:0] a, input logic [2:0] rgn, input logic [15:0] off);
    da_addr = a;
    @(posedge clk); #1;
    chk("R11 region", 32'(da_region), 32'(rgn));
    chk("R11 offset", 32'(da_offset), 32'(off));
  endtask

  task automatic t_decode();
    dec_one(16'h0000, 3'b001, 16'h0000);
    dec_one(16'h001F, 3'b001, 16'h001F);
    dec_one(16'h0020, 3'b010, 16'h0000);
    dec_one(16'h005F, 3'b010, 16'h003F);
    dec_one(16'h0060, 3'b100, 16'h0000);
    dec_one(16'hFFFF, 3'b100, 16'hFF9F);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1; rd_a_idx = 0; rd_b_idx = 0; da_addr = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_narrow();
    t_wide();
    t_postinc();
    t_predec();
    t_disp();
    t_prio();
    t_decode();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule